// File: doc/BRIEF.md
# DDR Burst Data Path with Strobes

This block is the data-side half of a DDR SDRAM controller. It runs on a fast clock at twice the command-clock rate, so each fast cycle ("slot") is one half of a command clock. An internal phase bit marks which slots are the high half of the command clock. Commands and user write words are taken only at the end of those slots, and the block reports them on `cmd_slot`.

On a write, the block takes one 2n-bit word per command cycle, together with its byte mask. It sends each word to the pins as two n-bit beats, low half first. The strobe it drives is modelled at slot resolution, with a quarter-cycle shift that is left to the pad stage, so that its edge falls in the middle of each beat. The burst is framed by a low preamble slot and a low postamble slot, and the strobe enable is high only across that frame.

On a read, the memory drives the strobe edge-aligned with the data. The block samples both inputs in every slot of a capture window that opens after the programmed CAS latency. It takes a beat wherever the strobe level changes and rebuilds each 2n-bit word, with a one-slot valid pulse.

Top module: `ddr_burst_datapath`

## Requirements
- R1: While reset is held and in the first slot after it, `dq_oe`, `dqs_oe`, `dqs_o`, `dm_o`, `dq_o` and `rd_valid` are all 0.
- R2: A write accepted at the end of slot T makes slot T+1 a preamble: `dqs_oe`=1, `dqs_o`=0, `dq_oe`=0.
- R3: Beat i of a write appears in slot T+2+i. It is bits [n-1:0] of word i/2 when i is even and bits [2n-1:n] when i is odd. Word k is sampled from `wr_data` at the end of the command slot k command cycles after the start slot.
- R4: During write beats, `dqs_o` is 1 on the first beat of each pair and 0 on the second. The first beat always lies in a slot where `cmd_slot` is 1, and `dq_oe` is never 1 while `dqs_oe` is 0.
- R5: On a write beat, `dm_o` carries the mask bits of that half: mask bit 0 for the low half and bit 1 for the high half at n=8. Whenever `dq_oe` is 0, including during reads, `dm_o` is 0.
- R6: The slot after the last beat is a postamble: `dqs_oe`=1, `dqs_o`=0, `dq_oe`=0. In the next slot `dqs_oe` is 0, unless a new write is accepted in that same command slot, in which case that slot becomes its preamble.
- R7: Burst code `bl_code` sets the beats per burst: 0 gives 2 beats, 1 gives 4, and 2 or 3 give 8 (1, 2 or 4 words).
- R8: For a read accepted at the end of slot T, beat 0 is sampled in slot T+4 when `cl_half`=0 (latency 2) and in slot T+5 when `cl_half`=1 (latency 2.5). The window lasts as many slots as there are beats.
- R9: Inside the window, a beat is taken when `dqs_i` differs from its level in the previous slot. A beat taken with `dqs_i`=1 is the low half and one taken with `dqs_i`=0 is the high half. The word then appears on `rd_data` with `rd_valid`=1 for exactly the slot that follows the high half.
- R10: Outside a read window, or inside one where `dqs_i` does not change, `rd_valid` stays 0 whatever `dq_i` and `dqs_i` do.
- R11: Starts are accepted only in command slots and only when the block is idle; starts at other times are ignored. A write and a read requested in the same slot start the write only.
- R12: While a read is in progress, `dqs_oe` and `dq_oe` stay 0, and `rd_valid` is never 1 while `dqs_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, twice the command clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_slot | output | 1 | 1 in slots that form the high half of the command clock |
| wr_start | input | 1 | Start a write burst |
| rd_start | input | 1 | Start a read capture |
| bl_code | input | 2 | Burst length code |
| cl_half | input | 1 | 0: CAS latency 2, 1: CAS latency 2.5 |
| wr_data | input | 2*DQ_W | Write word, one per command cycle |
| wr_mask | input | DQ_W/4 | Byte mask for the write word |
| dq_o | output | DQ_W | Data beat to the pins |
| dq_oe | output | 1 | Data output enable |
| dm_o | output | DQ_W/8 | Data mask for the current beat |
| dqs_o | output | 1 | Write strobe level |
| dqs_oe | output | 1 | Strobe output enable |
| dq_i | input | DQ_W | Read data beat from the pins |
| dqs_i | input | 1 | Read strobe from the memory |
| rd_data | output | 2*DQ_W | Reassembled read word |
| rd_valid | output | 1 | One-slot pulse per read word |

## Verification
The hardest case to reach is a command slot that is itself a postamble slot: a new write accepted there must turn that postamble straight into a preamble. This needs a second write issued in the exact slot the first burst frees up. The bench chains writes back to back to hit it, and pokes starts into the middle of bursts to show they are ignored. Reads are driven with both latencies, with a strobe that never toggles, and with strobe activity while idle. The random part mixes burst lengths, latencies and data under a fixed seed.

// File: rtl/ddr_burst_datapath.sv
module ddr_burst_datapath #(
  parameter int DQ_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                cmd_slot,
  input  logic                wr_start,
  input  logic                rd_start,
  input  logic [1:0]          bl_code,
  input  logic                cl_half,
  input  logic [2*DQ_W-1:0]   wr_data,
  input  logic [DQ_W/4-1:0]   wr_mask,
  output logic [DQ_W-1:0]     dq_o,
  output logic                dq_oe,
  output logic [DQ_W/8-1:0]   dm_o,
  output logic                dqs_o,
  output logic                dqs_oe,
  input  logic [DQ_W-1:0]     dq_i,
  input  logic                dqs_i,
  output logic [2*DQ_W-1:0]   rd_data,
  output logic                rd_valid
);
  localparam int WORD_W = 2 * DQ_W;
  localparam int MB     = DQ_W / 8;
  localparam int MW     = 2 * MB;

  typedef enum logic [1:0] {S_IDLE, S_WDAT, S_WPOST, S_RD} st_t;

  st_t               st;
  logic              ph;
  logic              sel;
  logic [3:0]        left;
  logic [3:0]        rt;
  logic [3:0]        lat;
  logic [3:0]        rlast;
  logic [WORD_W-1:0] wbuf;
  logic [MW-1:0]     mbuf;
  logic [DQ_W-1:0]   lo_buf;
  logic              dqs_q;

  assign cmd_slot = ~ph;

  logic [3:0] beats_n;
  logic [3:0] lat_n;
  assign beats_n = (bl_code == 2'd0) ? 4'd2 : (bl_code == 2'd1) ? 4'd4 : 4'd8;
  assign lat_n   = cl_half ? 4'd5 : 4'd4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= 1'b0;
      sel      <= 1'b0;
      left     <= '0;
      rt       <= '0;
      lat      <= '0;
      rlast    <= '0;
      wbuf     <= '0;
      mbuf     <= '0;
      lo_buf   <= '0;
      dqs_q    <= 1'b0;
      dq_o     <= '0;
      dq_oe    <= 1'b0;
      dm_o     <= '0;
      dqs_o    <= 1'b0;
      dqs_oe   <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      ph       <= ~ph;
      dqs_q    <= dqs_i;
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: begin
          dq_o   <= '0;
          dq_oe  <= 1'b0;
          dm_o   <= '0;
          dqs_o  <= 1'b0;
          dqs_oe <= 1'b0;
          if (cmd_slot && wr_start) begin
            dqs_oe <= 1'b1;
            wbuf   <= wr_data;
            mbuf   <= wr_mask;
            left   <= beats_n;
            sel    <= 1'b0;
            st     <= S_WDAT;
          end else if (cmd_slot && rd_start) begin
            rt    <= 4'd1;
            lat   <= lat_n;
            rlast <= lat_n + beats_n - 4'd1;
            st    <= S_RD;
          end
        end
        S_WDAT: begin
          dq_oe  <= 1'b1;
          dqs_oe <= 1'b1;
          sel    <= ~sel;
          left   <= left - 4'd1;
          if (!sel) begin
            dq_o  <= wbuf[DQ_W-1:0];
            dm_o  <= mbuf[MB-1:0];
            dqs_o <= 1'b1;
          end else begin
            dq_o  <= wbuf[WORD_W-1:DQ_W];
            dm_o  <= mbuf[MW-1:MB];
            dqs_o <= 1'b0;
            wbuf  <= wr_data;
            mbuf  <= wr_mask;
          end
          if (left == 4'd1) st <= S_WPOST;
        end
        S_WPOST: begin
          dq_o  <= '0;
          dq_oe <= 1'b0;
          dm_o  <= '0;
          dqs_o <= 1'b0;
          st    <= S_IDLE;
        end
        S_RD: begin
          rt <= rt + 4'd1;
          if (rt >= lat && dqs_i != dqs_q) begin
            if (dqs_i) begin
              lo_buf <= dq_i;
            end else begin
              rd_data  <= {dq_i, lo_buf};
              rd_valid <= 1'b1;
            end
          end
          if (rt == rlast) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ddr_burst_datapath_chk.sv
module ddr_burst_datapath_chk #(
  parameter int DQ_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_slot,
  input logic              dq_oe,
  input logic [DQ_W/8-1:0] dm_o,
  input logic              dqs_o,
  input logic              dqs_oe,
  input logic              rd_valid
);
  AST_PREAMBLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dqs_oe) |-> (!dqs_o && !dq_oe)); // R2

  AST_DATA_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> dqs_oe); // R4

  AST_STROBE_PAIR_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (dqs_o == cmd_slot)); // R4

  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dm_o == '0)); // R5

  AST_POSTAMBLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dqs_oe) |-> $past(!dq_oe && !dqs_o)); // R6

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R9

  AST_NO_READ_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_oe |-> !rd_valid); // R12
endmodule

bind ddr_burst_datapath ddr_burst_datapath_chk #(.DQ_W(DQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_slot(cmd_slot), .dq_oe(dq_oe), .dm_o(dm_o),
  .dqs_o(dqs_o), .dqs_oe(dqs_oe), .rd_valid(rd_valid)
);

// File: tb/ddr_burst_datapath_tb.sv
module ddr_burst_datapath_tb;
  localparam int CLK_P = 10;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_slot;
  logic         wr_start = 1'b0;
  logic         rd_start = 1'b0;
  logic [1:0]   bl_code = 2'd0;
  logic         cl_half = 1'b0;
  logic [2*N-1:0] wr_data = '0;
  logic [1:0]   wr_mask = '0;
  logic [N-1:0] dq_o;
  logic         dq_oe;
  logic [0:0]   dm_o;
  logic         dqs_o;
  logic         dqs_oe;
  logic [N-1:0] dq_i = '0;
  logic         dqs_i = 1'b0;
  logic [2*N-1:0] rd_data;
  logic         rd_valid;

  int nvec = 0;
  int nbad = 0;

  always #(CLK_P/2) clk = ~clk;

  ddr_burst_datapath #(.DQ_W(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_slot(cmd_slot), .wr_start(wr_start),
    .rd_start(rd_start), .bl_code(bl_code), .cl_half(cl_half),
    .wr_data(wr_data), .wr_mask(wr_mask), .dq_o(dq_o), .dq_oe(dq_oe),
    .dm_o(dm_o), .dqs_o(dqs_o), .dqs_oe(dqs_oe), .dq_i(dq_i), .dqs_i(dqs_i),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int beats_of(input int blc);
    return (blc == 0) ? 2 : (blc == 1) ? 4 : 8;
  endfunction

  function automatic logic [N-1:0] half_of(input logic [2*N-1:0] w, input int h);
    return h[0] ? w[2*N-1:N] : w[N-1:0];
  endfunction

  task automatic sync_cmd();
    while (!cmd_slot) @(negedge clk);
  endtask

  task automatic do_write(input int blc, input bit poke, input bit both);
    int b = beats_of(blc);
    logic [2*N-1:0] w[4];
    logic [1:0] m[4];
    for (int k = 0; k < 4; k++) begin
      w[k] = 16'($urandom);
      m[k] = 2'($urandom);
    end
    sync_cmd();
    wr_start = 1'b1;
    rd_start = both;
    bl_code  = 2'(blc);
    wr_data  = w[0];
    wr_mask  = m[0];
    for (int j = 1; j <= b + 2; j++) begin
      @(negedge clk);
      wr_start = poke && (j == 2);
      rd_start = poke && (j == 2);
      if (poke && j == 2) bl_code = 2'($urandom);
      if ((j % 2) == 0 && (j / 2) < 4) begin
        wr_data = w[j/2];
        wr_mask = m[j/2];
      end
      chk(rd_valid == 1'b0, "R12", "rd_valid during write", 32'(rd_valid), 0);
      if (j == 1) begin
        chk(dqs_oe && !dqs_o && !dq_oe, "R2", "preamble oe/dqs/dq_oe",
            {dqs_oe, dqs_o, dq_oe}, 32'b100);
      end else if (j <= b + 1) begin
        int i = j - 2;
        chk(dq_oe && dqs_oe, "R4", "beat enables", {dqs_oe, dq_oe}, 32'b11);
        chk(dq_o == half_of(w[i/2], i % 2), "R3", "beat data", 32'(dq_o),
            32'(half_of(w[i/2], i % 2)));
        chk(dqs_o == ((i % 2) == 0), "R4", "strobe level", 32'(dqs_o),
            32'((i % 2) == 0));
        chk(dm_o[0] == m[i/2][i%2], "R5", "mask bit", 32'(dm_o),
            32'(m[i/2][i%2]));
      end else begin
        chk(dqs_oe && !dqs_o && !dq_oe, "R6", "postamble oe/dqs/dq_oe",
            {dqs_oe, dqs_o, dq_oe}, 32'b100);
        chk(dm_o == 1'b0, "R5", "mask in postamble", 32'(dm_o), 0);
      end
    end
    wr_start = 1'b0;
    rd_start = 1'b0;
  endtask

  task automatic check_released();
    @(negedge clk);
    chk(dqs_oe == 1'b0 && dq_oe == 1'b0, "R6", "strobe released after postamble",
        {dqs_oe, dq_oe}, 0);
  endtask

  // mode 0: normal, 1: strobe never toggles, 2: write start poked mid-read
  task automatic do_read(input int blc, input bit clh, input int mode);
    int b = beats_of(blc);
    int lat = clh ? 5 : 4;
    logic [2*N-1:0] r[4];
    for (int k = 0; k < 4; k++) r[k] = 16'($urandom);
    sync_cmd();
    rd_start = 1'b1;
    bl_code  = 2'(blc);
    cl_half  = clh;
    dqs_i    = 1'b0;
    for (int j = 1; j <= lat + b + 1; j++) begin
      @(negedge clk);
      rd_start = 1'b0;
      wr_start = (mode == 2) && (j == 2);
      if (mode != 1 && j >= lat + 2 && ((j - lat) % 2) == 0 && j <= lat + b) begin
        int k = (j - lat - 2) / 2;
        chk(rd_valid == 1'b1, clh ? "R8" : "R9", "rd_valid for word", 32'(rd_valid), 1);
        chk(rd_data == r[k], "R9", "read word order", 32'(rd_data), 32'(r[k]));
      end else begin
        chk(rd_valid == 1'b0, mode == 1 ? "R10" : "R8", "rd_valid quiet", 32'(rd_valid), 0);
      end
      chk(!dqs_oe && !dq_oe && dm_o == 1'b0, mode == 2 ? "R11" : "R12",
          "no drive during read", {dqs_oe, dq_oe, dm_o}, 0);
      if (j >= lat && j < lat + b) begin
        int i = j - lat;
        dqs_i = (mode == 1) ? 1'b0 : ((i % 2) == 0);
        dq_i  = half_of(r[i/2], i % 2);
      end else begin
        dqs_i = 1'b0;
        dq_i  = N'($urandom);
      end
    end
    wr_start = 1'b0;
  endtask

  task automatic idle_noise(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      dqs_i = ~dqs_i;
      dq_i  = N'($urandom);
      chk(rd_valid == 1'b0, "R10", "rd_valid with no read", 32'(rd_valid), 0);
    end
    dqs_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_0d5));
    repeat (4) @(negedge clk);
    chk({dq_oe, dqs_oe, dqs_o, dm_o, rd_valid} == 5'b0 && dq_o == '0, "R1",
        "outputs in reset", {dq_oe, dqs_oe, dqs_o, dm_o, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({dq_oe, dqs_oe, dqs_o, dm_o, rd_valid} == 5'b0, "R1",
        "outputs after reset", {dq_oe, dqs_oe, dqs_o, dm_o, rd_valid}, 0);

    // R7: each burst code
    for (int c = 0; c < 4; c++) begin
      do_write(c, 1'b0, 1'b0);
      check_released();
    end
    // R6: back-to-back writes, second accepted in postamble slot
    do_write(1, 1'b0, 1'b0);
    do_write(0, 1'b0, 1'b0);
    do_write(2, 1'b0, 1'b0);
    check_released();
    // R11: starts poked mid-burst are ignored; write wins over read
    do_write(2, 1'b1, 1'b0);
    check_released();
    do_write(1, 1'b0, 1'b1);
    check_released();
    // R8/R9: both latencies, every length
    for (int c = 0; c < 3; c++) begin
      do_read(c, 1'b0, 0);
      do_read(c, 1'b1, 0);
    end
    do_read(2, 1'b0, 1);
    do_read(1, 1'b1, 2);
    idle_noise(12);
    do_write(0, 1'b0, 1'b0);
    do_read(0, 1'b1, 0);

    for (int t = 0; t < 60; t++) begin
      int op = int'($urandom % 3);
      int c  = int'($urandom % 4);
      if (op == 0) begin
        do_write(c, ($urandom % 4) == 0, 1'b0);
        if ($urandom % 2) check_released();
      end else if (op == 1) begin
        do_read(c % 3, 1'($urandom), 0);
      end else begin
        idle_noise(3);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule